// File: doc/BRIEF.md
# Channel-Routed Event Packet Switch

This block sits in a tree of timing-event links. Event packets arrive on a single upstream port and each one leaves on exactly one of several downstream ports or on a local output. The destination depends only on the 16-bit channel number in the packet's first word. Software does not pick an address window for each port. Instead it writes one channel offset per downstream port. The packet goes to the port whose offset is the largest one not above the channel number. Before the header leaves, the switch subtracts that port's offset from the channel number, so every child sees channel numbers counted from zero.

All ports use valid/ready handshaking. The header word is held for one cycle in a registered compare stage while the port is chosen. The payload words that follow pass straight through to the same port until the end-of-packet marker, with no whole-packet buffering. Software walks the tree with an enumeration query. The switch answers it on a response port with its child-port count and the DMA-capable flags that software wrote for each port. Header word layout: bits [31:30] are the packet kind (01 is an enumeration query, any other value is an event), bits [29:16] pass through untouched, and bits [15:0] hold the channel number.

Top module: `evt_route_switch`

## Requirements
- R1: After reset no output or response is valid and the upstream port is ready. All offsets read as zero (disabled) and all DMA flags are clear, so every event leaves on the local output (index 0) with its channel unchanged.
- R2: A downstream port k (output index k+1, k = 0..3) is eligible when its offset is non-zero and not greater than the channel. The eligible port with the largest offset is chosen. On equal offsets the lowest index wins.
- R3: An event whose channel is below every enabled offset goes to the local output with its channel unchanged.
- R4: The forwarded header carries the channel minus the chosen port's offset in bits [15:0], and bits [31:16] unchanged. Payload words are forwarded unchanged.
- R5: All words of a packet leave on the same output, in order. out_last is set only on the final word.
- R6: While an output is valid and not ready, its valid and data stay stable and no word is lost or repeated.
- R7: An upstream query (kind 01) produces one response whose bits [7:0] are the child count 4 and whose bits [11:8] are the DMA flags. Any further words of the query are consumed. No data output goes valid for it.
- R8: A write to address 4 sets the four DMA flags from wdata[3:0].
- R9: At most one data output is valid in any cycle.
- R10: A forwarded header appears on its output in the cycle after the upstream accepts it. Payload words are presented combinationally in the same cycle they are offered upstream.
- R11: A write to address 0..3 sets that port's offset. Writes to addresses 5..7 change no offset and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address: 0..3 offsets, 4 DMA flags |
| cfg_wdata | input | 16 | Configuration write data |
| up_valid | input | 1 | Upstream word valid |
| up_ready | output | 1 | Upstream word accepted when high with valid |
| up_data | input | 32 | Upstream word |
| up_last | input | 1 | Upstream end-of-packet marker |
| out_valid | output | 5 | Per-output valid, index 0 local, 1..4 downstream |
| out_ready | input | 5 | Per-output ready |
| out_data | output | 32 | Shared outgoing word |
| out_last | output | 1 | Outgoing end-of-packet marker |
| rsp_valid | output | 1 | Enumeration response valid |
| rsp_ready | input | 1 | Enumeration response accepted |
| rsp_data | output | 16 | Child count [7:0], DMA flags [11:8] |

## Verification
The hardest case to reach from the ports is an output that stalls in the middle of a packet, while the held header waits in the compare stage and the payload passes straight through. It matters most when the upstream offers words with gaps at the same time. The stimulus produces it by pulling each ready low at random and by inserting random upstream bubbles, over packets of several lengths. Directed cases cover channels that land exactly on an offset, ties between equal offsets, offsets programmed out of order, and multi-word queries that must be drained.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
    typedef enum logic [1:0] {
        ST_HDR   = 2'd0,
        ST_SEND  = 2'd1,
        ST_BODY  = 2'd2,
        ST_DRAIN = 2'd3
    } route_fsm_e;

    localparam logic [1:0] KIND_QUERY = 2'b01;
    localparam int         RSP_W      = 16;
    localparam int         CNT_W      = 8;
endpackage

// File: rtl/evt_route_cfg.sv
module evt_route_cfg #(
    parameter int NDOWN  = 4,
    parameter int CHAN_W = 16,
    parameter int AW     = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [CHAN_W-1:0]              wdata,
    output logic [NDOWN-1:0][CHAN_W-1:0]   offsets,
    output logic [NDOWN-1:0]               dma_flags
);
    typedef struct packed {
        logic [NDOWN-1:0][CHAN_W-1:0] off;
        logic [NDOWN-1:0]             dma;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int k = 0; k < NDOWN; k++) begin
            if (we && addr == AW'(k)) begin
                cfg_d.off[k] = wdata;
            end
        end
        if (we && addr == AW'(NDOWN)) begin
            cfg_d.dma = wdata[NDOWN-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign offsets   = cfg_q.off;
    assign dma_flags = cfg_q.dma;

    assert_flag_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(NDOWN)) |=> (dma_flags == $past(wdata[NDOWN-1:0])));
endmodule

// File: rtl/evt_route_match.sv
module evt_route_match #(
    parameter int NDOWN  = 4,
    parameter int CHAN_W = 16
) (
    input  logic [CHAN_W-1:0]              chan,
    input  logic [NDOWN-1:0][CHAN_W-1:0]   offsets,
    output logic [NDOWN-1:0]               hit
);
    for (genvar k = 0; k < NDOWN; k++) begin : g_cmp
        assign hit[k] = (offsets[k] != '0) && (offsets[k] <= chan);
    end
endmodule

// File: rtl/evt_route_pick.sv
module evt_route_pick #(
    parameter int NDOWN  = 4,
    parameter int CHAN_W = 16,
    parameter int PW     = 3
) (
    input  logic [NDOWN-1:0]               hit,
    input  logic [NDOWN-1:0][CHAN_W-1:0]   offsets,
    output logic [PW-1:0]                  port,
    output logic [CHAN_W-1:0]              base
);
    logic found;

    always_comb begin
        port  = '0;
        base  = '0;
        found = 1'b0;
        for (int k = 0; k < NDOWN; k++) begin
            if (hit[k] && (!found || offsets[k] > base)) begin
                found = 1'b1;
                base  = offsets[k];
                port  = PW'(k + 1);
            end
        end
    end
endmodule

// File: rtl/evt_route_switch.sv
module evt_route_switch
    import evt_route_pkg::*;
#(
    parameter int NDOWN  = 4,
    parameter int DATA_W = 32,
    parameter int CHAN_W = 16,
    parameter int AW     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [CHAN_W-1:0]    cfg_wdata,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [DATA_W-1:0]    up_data,
    input  logic                 up_last,
    output logic [NDOWN:0]       out_valid,
    input  logic [NDOWN:0]       out_ready,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_last,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [RSP_W-1:0]     rsp_data
);
    localparam int NOUT = NDOWN + 1;
    localparam int PW   = $clog2(NOUT);

    typedef struct packed {
        route_fsm_e        fsm;
        logic [DATA_W-1:0] hdr;
        logic              last;
        logic              query;
        logic [PW-1:0]     sel;
        logic [CHAN_W-1:0] base;
    } route_t;

    route_t r_d, r_q;

    logic [NDOWN-1:0][CHAN_W-1:0] offsets;
    logic [NDOWN-1:0]             dma_flags;
    logic [NDOWN-1:0]             hit;
    logic [PW-1:0]                pick_port;
    logic [CHAN_W-1:0]            pick_base;
    logic [NOUT-1:0]              sel_oh;
    logic                         sel_ready;

    evt_route_cfg #(.NDOWN(NDOWN), .CHAN_W(CHAN_W), .AW(AW)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .offsets   (offsets),
        .dma_flags (dma_flags)
    );

    evt_route_match #(.NDOWN(NDOWN), .CHAN_W(CHAN_W)) i_match (
        .chan    (up_data[CHAN_W-1:0]),
        .offsets (offsets),
        .hit     (hit)
    );

    evt_route_pick #(.NDOWN(NDOWN), .CHAN_W(CHAN_W), .PW(PW)) i_pick (
        .hit     (hit),
        .offsets (offsets),
        .port    (pick_port),
        .base    (pick_base)
    );

    always_comb begin
        for (int i = 0; i < NOUT; i++) begin
            sel_oh[i] = (r_q.sel == PW'(i));
        end
        sel_ready = |(sel_oh & out_ready);

        rsp_data                = '0;
        rsp_data[CNT_W-1:0]     = CNT_W'(NDOWN);
        rsp_data[CNT_W+:NDOWN]  = dma_flags;
    end

    always_comb begin
        r_d       = r_q;
        up_ready  = 1'b0;
        out_valid = '0;
        out_data  = up_data;
        out_last  = up_last;
        rsp_valid = 1'b0;
        unique case (r_q.fsm)
            ST_HDR: begin
                up_ready = 1'b1;
                if (up_valid) begin
                    r_d.hdr   = up_data;
                    r_d.last  = up_last;
                    r_d.query = (up_data[DATA_W-1 -: 2] == KIND_QUERY);
                    r_d.sel   = pick_port;
                    r_d.base  = pick_base;
                    r_d.fsm   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (r_q.query) begin
                    rsp_valid = 1'b1;
                    if (rsp_ready) begin
                        r_d.fsm = r_q.last ? ST_HDR : ST_DRAIN;
                    end
                end else begin
                    out_valid = sel_oh;
                    out_data  = {r_q.hdr[DATA_W-1:CHAN_W],
                                 r_q.hdr[CHAN_W-1:0] - r_q.base};
                    out_last  = r_q.last;
                    if (sel_ready) begin
                        r_d.fsm = r_q.last ? ST_HDR : ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                out_valid = up_valid ? sel_oh : '0;
                up_ready  = sel_ready;
                if (up_valid && sel_ready && up_last) begin
                    r_d.fsm = ST_HDR;
                end
            end
            ST_DRAIN: begin
                up_ready = 1'b1;
                if (up_valid && up_last) begin
                    r_d.fsm = ST_HDR;
                end
            end
            default: r_d.fsm = ST_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.fsm <= ST_HDR;
        end else begin
            r_q <= r_d;
        end
    end

    assert_onehot_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_hold_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == ST_SEND && !r_q.query && !sel_ready)
        |=> ($stable(out_data) && $stable(out_valid)));

    assert_hdr_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == ST_HDR && up_valid && up_data[DATA_W-1 -: 2] != KIND_QUERY)
        |=> (out_valid != '0));

    assert_query_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (out_valid == '0));
endmodule

// File: tb/test_evt_route_switch.sv
module test_evt_route_switch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_data = '0;
    logic        up_last = 1'b0;
    logic [4:0]  out_valid;
    logic [4:0]  out_ready = '1;
    logic [31:0] out_data;
    logic        out_last;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [15:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;
    int offs [4];
    int flags = 0;
    bit stall_mode = 1'b0;

    logic [31:0] words   [8];
    logic [31:0] cap_d   [16];
    int          cap_p   [16];
    bit          cap_l   [16];

    always #2 clk = ~clk;

    evt_route_switch i_evt_route_switch (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data), .up_last(up_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_port(input int ch);
        int best = 0;
        int boff = 0;
        for (int k = 0; k < 4; k++) begin
            if (offs[k] != 0 && offs[k] <= ch && (best == 0 || offs[k] > boff)) begin
                best = k + 1;
                boff = offs[k];
            end
        end
        return best;
    endfunction

    function automatic int exp_base(input int p);
        return (p == 0) ? 0 : offs[p-1];
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        if (a < 4) offs[a] = d & 16'hFFFF;
        if (a == 4) flags = d & 4'hF;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_pkt(input int n, input bit query, input int ch);
        int idx = 0, ncap = 0, cyc = 0, acc_cyc = -1, first_cyc = -1;
        bit offering = 0, got_rsp = 0, stall_bad = 0, onehot_bad = 0, quiet_bad = 0;
        bit prev_stall = 0;
        logic [4:0]  prev_v = '0;
        logic [31:0] prev_d = '0;
        logic [15:0] rsp_v = '0;
        int p, b;
        words[0] = {query ? 2'b01 : 2'b00, 14'($urandom), 16'(ch)};
        for (int i = 1; i < n; i++) words[i] = $urandom;
        while (!(idx == n && (query ? got_rsp : ncap >= n)) && cyc < 2000) begin
            @(negedge clk);
            if (idx < n && !offering && ($urandom % 4 != 0)) offering = 1;
            up_valid = offering;
            up_data  = offering ? words[idx] : 32'h0;
            up_last  = offering && (idx == n - 1);
            out_ready = stall_mode ? 5'($urandom) : 5'h1F;
            rsp_ready = stall_mode ? 1'($urandom) : 1'b1;
            #1;
            if (prev_stall && (out_valid != prev_v || out_data != prev_d)) stall_bad = 1;
            if ($countones(out_valid) > 1) onehot_bad = 1;
            if (query && out_valid != 0) quiet_bad = 1;
            if (out_valid != 0 && first_cyc < 0) first_cyc = cyc;
            for (int i = 0; i < 5; i++) begin
                if (out_valid[i] && out_ready[i] && ncap < 16) begin
                    cap_d[ncap] = out_data; cap_p[ncap] = i; cap_l[ncap] = out_last;
                    ncap++;
                end
            end
            if (rsp_valid && rsp_ready) begin got_rsp = 1; rsp_v = rsp_data; end
            prev_stall = (out_valid & ~out_ready) != 0;
            prev_v = out_valid; prev_d = out_data;
            if (up_valid && up_ready) begin
                if (idx == 0) acc_cyc = cyc;
                idx++; offering = 0;
            end
            cyc++;
        end
        @(negedge clk);
        up_valid = 0; up_last = 0; out_ready = '1; rsp_ready = 1;
        chk(cyc < 2000, "R5 packet completes", 32'(cyc), 32'd2000);
        chk(!onehot_bad, "R9 single valid output", 32'(onehot_bad), 0);
        chk(!stall_bad, "R6 stable under stall", 32'(stall_bad), 0);
        if (query) begin
            chk(got_rsp && rsp_v == 16'({4'(flags), 8'd4}), "R7/R8 enumeration reply",
                32'(rsp_v), 32'({4'(flags), 8'd4}));
            chk(!quiet_bad && ncap == 0, "R7 no data output on query", 32'(ncap), 0);
        end else begin
            p = exp_port(ch);
            b = exp_base(p);
            chk(ncap == n, "R5 word count", 32'(ncap), 32'(n));
            chk(cap_p[0] == p, "R2/R3 selected output", 32'(cap_p[0]), 32'(p));
            chk(cap_d[0] == {words[0][31:16], 16'(ch - b)}, "R4 rewritten header",
                cap_d[0], {words[0][31:16], 16'(ch - b)});
            chk(first_cyc == acc_cyc + 1, "R10 header latency", 32'(first_cyc), 32'(acc_cyc + 1));
            for (int i = 1; i < n && i < ncap; i++) begin
                chk(cap_d[i] == words[i] && cap_p[i] == p, "R4/R5 payload word", cap_d[i], words[i]);
            end
            for (int i = 0; i < ncap; i++) begin
                chk(cap_l[i] == (i == n - 1), "R5 end marker", 32'(cap_l[i]), 32'(i == n - 1));
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int k = 0; k < 4; k++) offs[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 0 && rsp_valid == 0 && up_ready == 1, "R1 reset outputs",
            {out_valid, rsp_valid, up_ready}, 32'h1);
        // R1: default offsets route everything locally, flags clear
        run_pkt(1, 0, 16'h1234);
        run_pkt(3, 0, 16'hFFFF);
        run_pkt(1, 1, 0);
        // R11: offsets, unmapped writes ignored
        cfg_write(0, 100); cfg_write(1, 200); cfg_write(2, 300); cfg_write(3, 400);
        @(negedge clk); cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = 16'h0005;
        @(negedge clk); cfg_addr = 3'd7; cfg_wdata = 16'h000F;
        @(negedge clk); cfg_we = 0;
        run_pkt(1, 1, 0);
        run_pkt(2, 0, 99);   // R3 below all
        run_pkt(2, 0, 100);  // R2 exact boundary
        run_pkt(2, 0, 299);
        run_pkt(4, 0, 450);
        run_pkt(1, 0, 16'hFFFF);
        // R2 ties and unordered offsets
        cfg_write(0, 500); cfg_write(1, 200); cfg_write(2, 200); cfg_write(3, 0);
        run_pkt(2, 0, 300);
        run_pkt(2, 0, 600);
        // R8 flags and multi-word query drain
        cfg_write(4, 16'hFFFA);
        run_pkt(3, 1, 0);
        run_pkt(2, 0, 250);
        // random traffic with stalls
        stall_mode = 1;
        for (int r = 0; r < 200; r++) begin
            if (r % 20 == 0) begin
                for (int k = 0; k < 4; k++) cfg_write(k, ($urandom % 3 == 0) ? 0 : int'($urandom % 65536));
                cfg_write(4, int'($urandom % 16));
            end
            run_pkt(1 + int'($urandom % 6), ($urandom % 8) == 0, int'($urandom % 65536));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule